// File: doc/BRIEF.md
# Word-Parallel CRC-32 Engine

This block computes a 32-bit cyclic redundancy check and absorbs a full 64-bit data word on every clock cycle. Each update is a single combinational XOR network. The network gives the same result as shifting the 64 bits one at a time through a serial CRC register. Its coefficients come from the serial recurrence, evaluated when the design elaborates. No lookup table is stored. A 32-bit state register holds the running remainder.

A user pulses `init` to start a message, which loads the seed value. The user then presents one data word per cycle with `valid` high. The running remainder is read from `crc_o` one cycle after the last word. The generator polynomial, the seed and the serial bit order within a word are parameters. The engine applies no reflection and no final inversion.

Top module: `par_crc64`

## Requirements
- R1: While `rst_n` is low, and after its release, `crc_o` equals the parameter SEED (default 32'h0000_0000) until the first update.
- R2: When `init` is high at a rising edge, `crc_o` equals SEED after that edge, whatever `valid` and `data_i` hold.
- R3: When `valid` is high and `init` is low at a rising edge, `crc_o` after that edge equals the result of 64 serial steps applied to the previous `crc_o`. A serial step for input bit b is: feedback = state[31] XOR b; shift the state left by one; if feedback is 1, XOR in POLY (default 32'h04C1_1DB7, x^32 term implied).
- R4: When `valid` and `init` are both low at a rising edge, `crc_o` keeps its value.
- R5: With FIRST_MSB = 1 (default), `data_i[63]` is the first serial bit and `data_i[0]` the last.
- R6: Starting from a zero state, an all-zero word leaves the state at zero. A word whose only set bit is the last serial bit gives exactly POLY.
- R7: With FIRST_MSB = 0, `data_i[0]` is the first serial bit and `data_i[63]` the last, with the same serial step as R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to SEED |
| init | input | 1 | Synchronous load of SEED; overrides `valid` |
| valid | input | 1 | Absorb `data_i` at this edge |
| data_i | input | 64 | Data word, serial order set by FIRST_MSB |
| crc_o | output | 32 | Current CRC state register |

## Verification
Each result lands exactly one rising edge after the cycle in which `init` or `valid` was presented, because the only register between input and output is the state register. The bench drives inputs on the falling edge. It compares `crc_o` with its bit-serial model on the next falling edge, after that single update edge and before new inputs are applied. Idle cycles between words are checked on the same schedule, and they must show no change.

// File: rtl/crc_pkg.sv
package crc_pkg;

   // Default generator for the 32-bit code, x^32 implied
   localparam logic [31:0] CRC32_GEN = 32'h04C1_1DB7;
   localparam logic [31:0] CRC32_ZERO_SEED = 32'h0000_0000;

   // Bit ordering of a data word into the serial recurrence
   typedef enum logic {
      ORDER_LSB_FIRST = 1'b0,
      ORDER_MSB_FIRST = 1'b1
   } word_order_e;

endpackage

// File: rtl/crc_bit_order.sv
// Presents a data word so that its highest index is the first serial bit.
module crc_bit_order #(
   parameter int  DW        = 64,
   parameter bit  FIRST_MSB = 1'b1
) (
   input  logic [DW-1:0] word_i,
   output logic [DW-1:0] word_o
);

   generate
      if (DW < 1) begin : g_bad_width
         $error("crc_bit_order: DW must be positive");
      end

      if (FIRST_MSB == crc_pkg::ORDER_MSB_FIRST) begin : g_pass
         assign word_o = word_i;
      end else begin : g_swap
         for (genvar b = 0; b < DW; b++) begin : g_bit
            assign word_o[b] = word_i[DW-1-b];
         end
      end
   endgenerate

endmodule

// File: rtl/crc_xor_net.sv
// Combinational next state equal to DW serial steps, bit DW-1 first.
module crc_xor_net #(
   parameter int          W    = 32,
   parameter int          DW   = 64,
   parameter logic [W-1:0] POLY = crc_pkg::CRC32_GEN
) (
   input  logic [W-1:0]  state_i,
   input  logic [DW-1:0] word_i,
   output logic [W-1:0]  next_o
);

   localparam int NIN = W + DW;

   // One serial pass over the whole word
   function automatic logic [W-1:0] run_serial(logic [W-1:0] s, logic [DW-1:0] d);
      logic [W-1:0] acc;
      logic         fb;
      acc = s;
      for (int k = DW - 1; k >= 0; k--) begin
         fb  = acc[W-1] ^ d[k];
         acc = {acc[W-2:0], 1'b0};
         if (fb) acc = acc ^ POLY;
      end
      return acc;
   endfunction

   // Response of the pass to each single input bit: state bits then data bits
   function automatic logic [NIN-1:0][W-1:0] unit_responses();
      logic [NIN-1:0][W-1:0] cols;
      for (int j = 0; j < W; j++)
         cols[j] = run_serial(W'(1) << j, '0);
      for (int k = 0; k < DW; k++)
         cols[W+k] = run_serial('0, DW'(1) << k);
      return cols;
   endfunction

   localparam logic [NIN-1:0][W-1:0] COLS = unit_responses();

   // Select which inputs feed output bit i
   function automatic logic [NIN-1:0] tap_row(int i);
      logic [NIN-1:0] r;
      for (int n = 0; n < NIN; n++)
         r[n] = COLS[n][i];
      return r;
   endfunction

   logic [NIN-1:0] joined;
   assign joined = {word_i, state_i};

   generate
      if (W < 2) begin : g_bad_w
         $error("crc_xor_net: W must be at least 2");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("crc_xor_net: generator needs its x^0 term");
      end

      for (genvar i = 0; i < W; i++) begin : g_row
         localparam logic [NIN-1:0] TAPS = tap_row(i);
         assign next_o[i] = ^(joined & TAPS);
      end
   endgenerate

endmodule

// File: rtl/crc_state_reg.sv
// Remainder register: reset and init load the seed, valid loads the update.
module crc_state_reg #(
   parameter int           W    = 32,
   parameter logic [W-1:0] SEED = crc_pkg::CRC32_ZERO_SEED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         valid,
   input  logic [W-1:0] next_i,
   output logic [W-1:0] state_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_o <= SEED;
      else if (init)   state_o <= SEED;
      else if (valid)  state_o <= next_i;
   end

   // Init wins over valid and always yields the seed
   p_init_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (state_o == SEED));

   // Idle cycles leave the remainder untouched
   p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !valid) |=> $stable(state_o));

endmodule

// File: rtl/par_crc64.sv
module par_crc64 #(
   parameter int           W         = 32,
   parameter int           DW        = 64,
   parameter logic [W-1:0] POLY      = crc_pkg::CRC32_GEN,
   parameter logic [W-1:0] SEED      = crc_pkg::CRC32_ZERO_SEED,
   parameter bit           FIRST_MSB = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          valid,
   input  logic [DW-1:0] data_i,
   output logic [W-1:0]  crc_o
);

   // Data word whose only set bit is the final serial bit
   localparam logic [DW-1:0] LAST_BIT_WORD = FIRST_MSB ? DW'(1) : (DW'(1) << (DW - 1));

   logic [DW-1:0] word_ord;
   logic [W-1:0]  next_state;

   crc_bit_order #(.DW(DW), .FIRST_MSB(FIRST_MSB)) u_order (
      .word_i (data_i),
      .word_o (word_ord)
   );

   crc_xor_net #(.W(W), .DW(DW), .POLY(POLY)) u_net (
      .state_i (crc_o),
      .word_i  (word_ord),
      .next_o  (next_state)
   );

   crc_state_reg #(.W(W), .SEED(SEED)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .init    (init),
      .valid   (valid),
      .next_i  (next_state),
      .state_o (crc_o)
   );

   // Zero is a fixed point of the linear update
   p_zero_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !init && crc_o == '0 && data_i == '0) |=> (crc_o == '0));

   // Final serial bit alone from zero state yields the generator
   p_last_bit_poly_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !init && crc_o == '0 && data_i == LAST_BIT_WORD) |=> (crc_o == POLY));

endmodule

// File: tb/par_crc64_tb.sv
module par_crc64_tb;

   localparam logic [31:0] GEN = 32'h04C1_1DB7;
   localparam logic [31:0] SEED = 32'h0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init = 1'b0;
   logic        valid = 1'b0;
   logic [63:0] data = '0;
   logic [31:0] crc_msb, crc_lsb;

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [31:0] exp_msb, exp_lsb;

   always #2 clk = ~clk;

   par_crc64 u_dut (
      .clk(clk), .rst_n(rst_n), .init(init), .valid(valid),
      .data_i(data), .crc_o(crc_msb)
   );

   par_crc64 #(.FIRST_MSB(1'b0)) u_dut_lsb (
      .clk(clk), .rst_n(rst_n), .init(init), .valid(valid),
      .data_i(data), .crc_o(crc_lsb)
   );

   // Bit-serial reference; msb_first picks which end is fed first
   function automatic logic [31:0] ref_word(logic [31:0] s, logic [63:0] d, bit msb_first);
      logic [31:0] acc = s;
      for (int k = 0; k < 64; k++) begin
         logic b = msb_first ? d[63-k] : d[k];
         logic fb = acc[31] ^ b;
         acc = {acc[30:0], 1'b0};
         if (fb) acc ^= GEN;
      end
      return acc;
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   // Drive one cycle, update the model, sample after the edge
   task automatic cycle(bit i_init, bit i_valid, logic [63:0] d, string req);
      @(negedge clk);
      init = i_init; valid = i_valid; data = d;
      if (i_init) begin
         exp_msb = SEED; exp_lsb = SEED;
      end else if (i_valid) begin
         exp_msb = ref_word(exp_msb, d, 1'b1);
         exp_lsb = ref_word(exp_lsb, d, 1'b0);
      end
      @(negedge clk);
      init = 1'b0; valid = 1'b0;
      check(req, crc_msb, exp_msb);
      check({req, " lsb-first R7"}, crc_lsb, exp_lsb);
   endtask

   initial begin
      exp_msb = SEED; exp_lsb = SEED;
      repeat (3) @(negedge clk);
      check("R1 reset", crc_msb, SEED);
      check("R1 reset lsb", crc_lsb, SEED);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", crc_msb, SEED);

      // R6 corner words
      cycle(1'b0, 1'b1, 64'h0, "R6 zero word");
      check("R6 zero stays zero", crc_msb, 32'h0);
      cycle(1'b0, 1'b1, 64'h1, "R6 last bit msb");
      check("R6 gives POLY", crc_msb, GEN);
      cycle(1'b1, 1'b0, '0, "R2 init");
      cycle(1'b0, 1'b1, 64'h8000_0000_0000_0000, "R7 last bit lsb");
      check("R6 R7 lsb gives POLY", crc_lsb, GEN);

      // R2: init with valid and data present
      cycle(1'b0, 1'b1, 64'hDEAD_BEEF_0123_4567, "R3 prime");
      cycle(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R2 init over valid");
      check("R2 seed", crc_msb, SEED);

      // Single-bit sweep from the seed and from a loaded state (R3, R5)
      for (int k = 0; k < 64; k++) begin
         cycle(1'b1, 1'b0, '0, "R2 init");
         cycle(1'b0, 1'b1, 64'h1 << k, "R5 single bit");
         cycle(1'b0, 1'b1, 64'h1 << (63 - k), "R3 chained bit");
      end

      // R4: idle cycles with busy data lines
      cycle(1'b0, 1'b1, 64'h0F0F_1234_AAAA_5555, "R3 load");
      for (int k = 0; k < 4; k++)
         cycle(1'b0, 1'b0, {$urandom, $urandom}, "R4 hold");

      // Random multi-word messages with idle gaps
      for (int m = 0; m < 300; m++) begin
         int len = 1 + ($urandom % 8);
         cycle(1'b1, 1'b0, '0, "R2 init");
         for (int w = 0; w < len; w++) begin
            cycle(1'b0, 1'b1, {$urandom, $urandom}, "R3 random word");
            if (($urandom % 4) == 0)
               cycle(1'b0, 1'b0, {$urandom, $urandom}, "R4 gap hold");
         end
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule